// File: doc/BRIEF.md
# Multi-Queue Message Mailbox with Per-User Interrupts

This block is a register-mapped mailbox that lets several processors on a chip pass 32-bit words to each other. It holds six independent hardware queues of four entries each. A bus write to a queue's data register appends a word, and a bus read from the same register removes and returns the oldest word. Each queue also has a read-only full flag and a read-only fill-level register, so software can poll the queue instead of waiting for an interrupt.

Four interrupt users each own a status register and an enable register. Every queue raises two kinds of event: an "arrival" event each time a word is accepted, and a "space" event each time a read takes the queue from full to not full. Each event is posted into every user's status register. An interrupt line is high while that user has a status bit that is also enabled. Software acknowledges events by writing ones to the status register. A revision word, two idle-policy configuration bits and a status word complete the 0x120-byte register window.

The bus port is a single synchronous request port. Each access takes one cycle. Read data is registered and appears one cycle after the request.

Top module: `mbox_hub`

## Requirements
- R1: Queue m (0..5) has its data register at byte offset 0x40+4m. An accepted write appends the word, and a read returns the words in the order they were written. Each queue holds 4 words.
- R2: Offset 0x80+4m reads 1 in bit 0 when queue m holds 4 words and 0 otherwise. Offset 0xC0+4m reads the fill level 0..4 in bits 2:0. All other bits of both registers read 0.
- R3: A write to a full queue is dropped: the contents and the fill level stay as they were. A read from an empty queue returns 0 and leaves the queue empty.
- R4: Status bit 2m is the arrival event of queue m and is set in all four users' status registers on each accepted write. Status bit 2m+1 is the space event of queue m and is set in all users when a read removes a word from a full queue. Status bits 31:12 read 0.
- R5: User u's status register is at 0x100+8u. A write to it clears exactly the bits written as 1 and leaves the other bits unchanged.
- R6: User u's enable register at 0x104+8u is read/write in bits 11:0. user_irq[u] is high in the cycle after any status/enable update that leaves a bit set in both registers, and low otherwise.
- R7: Offset 0x00 reads the revision value 0x00000042 and ignores writes. Offset 0x10 holds read/write bits 0 and 4, and its other bits read 0. Offset 0x14 reads 0x00000001.
- R8: Read data appears on bus_rdata in the cycle after the read request. Reads of offsets that are not mapped return 0, and writes to them have no effect.
- R9: Synchronous active-high reset empties all queues and clears all status, enable and configuration bits, so all user_irq lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| user_irq | output | 4 | Interrupt line of each user |

## Verification
A queue pointer or fill level that is wrong shows up at the ports on the next read of that queue's data, full or count register. It appears as a word out of order, a missing word, a nonzero word from an empty queue, or a wrong level. An event bit that is missed or misrouted shows up one cycle later as a user_irq line that differs from the value predicted from the bench's own status and enable model. It also shows up on the next status readback. The bench mixes random traffic over all queues and users with directed fill, overflow, drain and acknowledge sequences. It checks each interrupt line after every access.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MB_NQ    = 6;
    localparam int MB_NU    = 4;
    localparam int MB_DEPTH = 4;
    localparam int MB_DW    = 32;
    localparam int MB_AW    = 9;

    // Byte offsets of the register groups
    localparam int OFF_REV   = 'h000;
    localparam int OFF_CFG   = 'h010;
    localparam int OFF_STAT  = 'h014;
    localparam int OFF_MSG   = 'h040;
    localparam int OFF_FULL  = 'h080;
    localparam int OFF_LEVEL = 'h0C0;
    localparam int OFF_IRQ   = 'h100;

    localparam int CFG_AUTO_BIT  = 0;
    localparam int CFG_SMART_BIT = 4;
endpackage

// File: rtl/mbox_queue.sv
module mbox_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DW-1:0]                wdata,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty,
    output logic                         ev_arrive,
    output logic                         ev_space
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rp;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
    } q_state_t;

    q_state_t st_q, st_d;
    logic accept, take;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign accept = push && !full;
    assign take   = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = bump(st_q.wp);
        end
        if (take) begin
            st_d.rp = bump(st_q.rp);
        end
        case ({accept, take})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head      = st_q.mem[st_q.rp];
    assign level     = st_q.cnt;
    assign ev_arrive = accept;
    assign ev_space  = take && full;
endmodule

// File: rtl/mbox_irq_bank.sv
module mbox_irq_bank #(
    parameter int EW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [EW-1:0] set_ev,
    input  logic          ack_wr,
    input  logic          en_wr,
    input  logic [EW-1:0] wdata,
    output logic [EW-1:0] status,
    output logic [EW-1:0] enable,
    output logic          irq
);
    typedef struct packed {
        logic [EW-1:0] status;
        logic [EW-1:0] enable;
    } bank_t;

    bank_t bk_q, bk_d;

    always_comb begin
        bk_d = bk_q;
        if (ack_wr) begin
            bk_d.status = bk_q.status & ~wdata;
        end
        // A fresh event in the same cycle survives an acknowledge
        bk_d.status = bk_d.status | set_ev;
        if (en_wr) begin
            bk_d.enable = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign status = bk_q.status;
    assign enable = bk_q.enable;
    assign irq    = |(bk_q.status & bk_q.enable);
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
    import mbox_pkg::*;
#(
    parameter int          NQ    = MB_NQ,
    parameter int          NU    = MB_NU,
    parameter int          DEPTH = MB_DEPTH,
    parameter int          DW    = MB_DW,
    parameter int          AW    = MB_AW,
    parameter logic [31:0] REV   = 32'h0000_0042
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NU-1:0] user_irq
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int EW = 2*NQ;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          auto_idle;
        logic          smart_idle;
    } hub_t;

    hub_t hs_q, hs_d;

    logic [NQ-1:0]          q_push, q_pop, q_full, q_empty, q_arrive, q_space;
    logic [NQ-1:0][DW-1:0]  q_head;
    logic [NQ-1:0][CW-1:0]  q_cnt;
    logic [NU-1:0]          u_ack, u_en;
    logic [NU-1:0][EW-1:0]  u_status, u_enable;
    logic [EW-1:0]          events;

    for (genvar m = 0; m < NQ; m++) begin : g_queue
        mbox_queue #(.DW(DW), .DEPTH(DEPTH)) u_q (
            .clk(clk), .rst(rst),
            .push(q_push[m]), .pop(q_pop[m]), .wdata(bus_wdata),
            .head(q_head[m]), .level(q_cnt[m]),
            .full(q_full[m]), .empty(q_empty[m]),
            .ev_arrive(q_arrive[m]), .ev_space(q_space[m])
        );
        assign events[2*m]   = q_arrive[m];
        assign events[2*m+1] = q_space[m];
    end

    for (genvar u = 0; u < NU; u++) begin : g_user
        mbox_irq_bank #(.EW(EW)) u_bank (
            .clk(clk), .rst(rst),
            .set_ev(events), .ack_wr(u_ack[u]), .en_wr(u_en[u]),
            .wdata(bus_wdata[EW-1:0]),
            .status(u_status[u]), .enable(u_enable[u]), .irq(user_irq[u])
        );
    end

    always_comb begin
        logic do_wr, do_rd;
        do_wr = bus_sel && bus_wr;
        do_rd = bus_sel && !bus_wr;
        hs_d = hs_q;
        hs_d.rdata = '0;
        q_push = '0;
        q_pop  = '0;
        u_ack  = '0;
        u_en   = '0;

        for (int m = 0; m < NQ; m++) begin
            if (bus_addr == AW'(OFF_MSG + 4*m)) begin
                q_push[m] = do_wr;
                q_pop[m]  = do_rd;
                if (do_rd && !q_empty[m]) hs_d.rdata = q_head[m];
            end
            if (do_rd && bus_addr == AW'(OFF_FULL + 4*m)) begin
                hs_d.rdata = DW'(q_full[m]);
            end
            if (do_rd && bus_addr == AW'(OFF_LEVEL + 4*m)) begin
                hs_d.rdata = DW'(q_cnt[m]);
            end
        end

        for (int u = 0; u < NU; u++) begin
            if (bus_addr == AW'(OFF_IRQ + 8*u)) begin
                u_ack[u] = do_wr;
                if (do_rd) hs_d.rdata = DW'(u_status[u]);
            end
            if (bus_addr == AW'(OFF_IRQ + 8*u + 4)) begin
                u_en[u] = do_wr;
                if (do_rd) hs_d.rdata = DW'(u_enable[u]);
            end
        end

        if (bus_addr == AW'(OFF_CFG)) begin
            if (do_wr) begin
                hs_d.auto_idle  = bus_wdata[CFG_AUTO_BIT];
                hs_d.smart_idle = bus_wdata[CFG_SMART_BIT];
            end
            if (do_rd) begin
                hs_d.rdata[CFG_AUTO_BIT]  = hs_q.auto_idle;
                hs_d.rdata[CFG_SMART_BIT] = hs_q.smart_idle;
            end
        end
        if (do_rd && bus_addr == AW'(OFF_STAT)) hs_d.rdata = DW'(1);
        if (do_rd && bus_addr == AW'(OFF_REV))  hs_d.rdata = DW'(REV);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign bus_rdata = hs_q.rdata;
endmodule

// File: rtl/mbox_hub_chk.sv
module mbox_hub_chk
    import mbox_pkg::*;
#(
    parameter int NQ    = MB_NQ,
    parameter int NU    = MB_NU,
    parameter int DEPTH = MB_DEPTH,
    parameter int DW    = MB_DW,
    parameter int AW    = MB_AW,
    parameter int CW    = $clog2(MB_DEPTH+1)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_wdata,
    input logic [DW-1:0]         bus_rdata,
    input logic [NU-1:0]         user_irq,
    input logic [NQ-1:0][CW-1:0] q_cnt
);
    localparam int EW = 2*NQ;

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (user_irq == '0 && q_cnt == '0));

    for (genvar m = 0; m < NQ; m++) begin : g_qchk
        a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
            q_cnt[m] <= CW'(DEPTH));

        a_r1_push_grows: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && bus_wr && bus_addr == AW'(OFF_MSG + 4*m) && q_cnt[m] < CW'(DEPTH))
            |=> q_cnt[m] == $past(q_cnt[m]) + CW'(1));

        a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && bus_wr && bus_addr == AW'(OFF_MSG + 4*m) && q_cnt[m] == CW'(DEPTH))
            |=> $stable(q_cnt[m]));

        a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && !bus_wr && bus_addr == AW'(OFF_MSG + 4*m) && q_cnt[m] == '0)
            |=> (bus_rdata == '0 && q_cnt[m] == '0));
    end

    for (genvar u = 0; u < NU; u++) begin : g_uchk
        a_r6_disable_quiets: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && bus_wr && bus_addr == AW'(OFF_IRQ + 8*u + 4) && bus_wdata[EW-1:0] == '0)
            |=> !user_irq[u]);
    end
endmodule

bind mbox_hub mbox_hub_chk #(
    .NQ(NQ), .NU(NU), .DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)
) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .user_irq(user_irq), .q_cnt(q_cnt)
);

// File: tb/tb_mbox_hub.sv
`timescale 1ns/1ps
module tb_mbox_hub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  user_irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mbox_hub dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .user_irq(user_irq)
    );

    // Reference model
    logic [31:0] mq [6][$];
    logic [11:0] mst [4];
    logic [11:0] men [4];
    logic        cfg_auto, cfg_smart;

    function automatic logic [8:0] a_msg(int m);   return 9'(32'h40 + 4*m); endfunction
    function automatic logic [8:0] a_full(int m);  return 9'(32'h80 + 4*m); endfunction
    function automatic logic [8:0] a_lvl(int m);   return 9'(32'hC0 + 4*m); endfunction
    function automatic logic [8:0] a_st(int u);    return 9'(32'h100 + 8*u); endfunction
    function automatic logic [8:0] a_en(int u);    return 9'(32'h104 + 8*u); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int u = 0; u < 4; u++) r[u] = |(mst[u] & men[u]);
        return r;
    endfunction

    task automatic chk_irq();
        chk("R6 irq", {28'b0, user_irq}, {28'b0, exp_irq()});
    endtask

    task automatic mb_push(int m, logic [31:0] d);
        do_write(a_msg(m), d);
        if (mq[m].size() < 4) begin
            mq[m].push_back(d);
            for (int u = 0; u < 4; u++) mst[u][2*m] = 1'b1;
        end
        chk_irq();
    endtask

    task automatic mb_pop(int m);
        logic [31:0] got, exp;
        do_read(a_msg(m), got);
        if (mq[m].size() == 0) begin
            exp = '0;
            chk("R3 empty read", got, exp);
        end else begin
            if (mq[m].size() == 4)
                for (int u = 0; u < 4; u++) mst[u][2*m+1] = 1'b1;
            exp = mq[m].pop_front();
            chk("R1 fifo order", got, exp);
        end
        chk_irq();
    endtask

    task automatic rd_chk(string req, logic [8:0] a, logic [31:0] exp);
        logic [31:0] got;
        do_read(a, got);
        chk(req, got, exp);
    endtask

    task automatic set_en(int u, logic [31:0] d);
        do_write(a_en(u), d);
        men[u] = d[11:0];
        chk_irq();
    endtask

    task automatic ack(int u, logic [31:0] d);
        do_write(a_st(u), d);
        mst[u] = mst[u] & ~d[11:0];
        chk_irq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int u = 0; u < 4; u++) begin mst[u] = '0; men[u] = '0; end
        cfg_auto = 0; cfg_smart = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        chk("R9 irq after reset", {28'b0, user_irq}, 32'h0);
        rd_chk("R9 level q0", a_lvl(0), 32'h0);
        rd_chk("R9 status u2", a_st(2), 32'h0);
        rd_chk("R7 revision", 9'h000, 32'h0000_0042);
        rd_chk("R7 status word", 9'h014, 32'h0000_0001);

        // R1/R2/R3/R4: fill queue 2 past full
        for (int i = 0; i < 5; i++) mb_push(2, 32'hA000_0000 + i);
        rd_chk("R2 full flag", a_full(2), 32'h1);
        rd_chk("R2 level", a_lvl(2), 32'h4);
        rd_chk("R4 arrival bit 4 in u3", a_st(3), 32'h0000_0010);
        set_en(1, 32'h10);
        chk("R6 u1 irq on", {28'b0, user_irq}, 32'h2);
        mb_pop(2);
        rd_chk("R4 space bit 5 in u0", a_st(0), 32'h0000_0030);
        rd_chk("R2 not full", a_full(2), 32'h0);
        for (int i = 0; i < 3; i++) mb_pop(2);
        mb_pop(2);
        rd_chk("R3 level stays 0", a_lvl(2), 32'h0);
        // R5: clear only bit 4 of user 1
        ack(1, 32'h10);
        rd_chk("R5 w1c keeps bit 5", a_st(1), 32'h20);
        chk("R6 u1 irq off", {28'b0, user_irq}, 32'h0);

        // R7/R8: config, read-only and unmapped
        do_write(9'h010, 32'hFFFF_FFFF);
        rd_chk("R7 cfg mask", 9'h010, 32'h0000_0011);
        do_write(9'h000, 32'h1234_5678);
        rd_chk("R7 revision write ignored", 9'h000, 32'h0000_0042);
        do_write(9'h020, 32'hFFFF_FFFF);
        rd_chk("R8 unmapped read", 9'h020, 32'h0);
        rd_chk("R8 misaligned read", 9'h041, 32'h0);
        chk_irq();

        // Random traffic
        for (int it = 0; it < 3000; it++) begin
            int op, m, u;
            logic [31:0] d;
            op = int'($urandom_range(0, 10));
            m  = int'($urandom_range(0, 5));
            u  = int'($urandom_range(0, 3));
            d  = $urandom();
            case (op)
                0, 1, 2: mb_push(m, d);
                3, 4:    mb_pop(m);
                5:       rd_chk("R2 full", a_full(m), {31'b0, mq[m].size() == 4});
                6:       rd_chk("R2 level", a_lvl(m), 32'(mq[m].size()));
                7:       set_en(u, d);
                8:       ack(u, d);
                9:       rd_chk("R4 status", a_st(u), {20'b0, mst[u]});
                default: rd_chk("R6 enable", a_en(u), {20'b0, men[u]});
            endcase
        end

        // R9: reset mid-traffic clears everything
        mb_push(0, 32'h5);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 6; i++) mq[i].delete();
        for (int i = 0; i < 4; i++) begin mst[i] = '0; men[i] = '0; end
        chk("R9 irq cleared", {28'b0, user_irq}, 32'h0);
        rd_chk("R9 queue emptied", a_lvl(0), 32'h0);
        rd_chk("R9 cfg cleared", 9'h010, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule